// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter with a four-word register bank. Software writes a reload value and clears the counter. It then enables counting and picks the tick source. On every enabled tick the counter either steps down by one or, when it has reached zero, takes the reload value again. Software gets a sticky wrap flag and an optional one-cycle interrupt request each time the count passes from one to zero.

Ticks come from one of two sources. The core clock gives one tick per cycle. A slower reference clock input is brought into the core domain, and each of its rising edges gives one tick. A read-only calibration word tells software whether a reference clock is fitted, whether its 10 ms figure is exact, and how many reference ticks make up 10 ms. All three values are fixed by parameters.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0 and irq_o is low.
- R2: Register word offsets are control 0x0, reload 0x4, current value 0x8 and calibration 0xC. Control bit 0 is enable, bit 1 is interrupt enable, bit 2 is tick source and bit 16 is the read-only wrap flag. Reload and current value use bits 23:0. Every other bit reads 0. An access whose address bits 1:0 are nonzero has no effect and reads 0.
- R3: With enable=1 and source=1 (core clock), each core cycle is a tick. On a tick the counter loads the reload value if it is 0, and otherwise decrements by one.
- R4: With a reload value of 0 the counter stays at 0, and the wrap flag and irq_o stay low.
- R5: While enable=0 the counter holds its value.
- R6: A write of any data to the current-value register sets the counter to 0 and clears the wrap flag. In that cycle it takes priority over a tick.
- R7: The wrap flag becomes 1 on a tick that steps the counter from 1 to 0. A read of the control register clears it. If a wrap and the clearing read fall in the same cycle, the wrap wins.
- R8: irq_o is high for exactly one core cycle, the cycle in which the wrap flag is newly set, and only if interrupt enable was 1 at that wrap.
- R9: With source=0, only rising edges of ref_clk_i produce ticks. The counter changes on the third core clock edge after ref_clk_i rises, because of a two-flop synchronizer and an edge detector. Falling edges and steady levels give no tick.
- R10: Calibration reads {no-reference flag at bit 31, inexact flag at bit 30, bits 29:24 zero, 10 ms tick count at bits 23:0}, all taken from parameters. Writes to it are ignored.
- R11: Reload accepts values up to 0xFFFFFF and drops write bits 31:24. A full-scale reload loads 0xFFFFFF and then decrements to 0xFFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset into the register bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
On every cycle the assertions check the counter's step rules: hold without a tick, decrement, reload at zero, and the clearing write. They also check that an interrupt pulse always comes with a set flag, follows an enabled interrupt, and never lasts two cycles. Some behaviour is visible only through the bench's scenarios. This covers the exact reference-edge latency, whether falling reference edges are ignored, the read-to-clear timing of the wrap flag, the register field layout and unused bits, the calibration constants, and a zero reload never wrapping.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CURR   = 2'd2,
    REG_CALIB  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_IE_BIT   = 1;
  localparam int unsigned CTRL_SRC_BIT  = 2;
  localparam int unsigned CTRL_WRAP_BIT = 16;
  localparam int unsigned CAL_NOREF_BIT = 31;
  localparam int unsigned CAL_SKEW_BIT  = 30;
endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          HAS_REF     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic en_i,
  input  logic core_src_i,
  output logic tick_o
);
  logic ref_rise;

  generate
    if (HAS_REF) begin : g_ref
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   last_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
          last_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], ref_clk_i};
          last_q <= sync_q[SYNC_STAGES-1];
        end
      end
      assign ref_rise = sync_q[SYNC_STAGES-1] & ~last_q;
    end else begin : g_no_ref
      logic unused_ref;
      assign unused_ref = ref_clk_i;
      assign ref_rise   = 1'b0;
    end
  endgenerate

  assign tick_o = en_i & (core_src_i | ref_rise);
endmodule

// File: rtl/tick_down_cnt.sv
module tick_down_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_i)     cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;
  end

  assign wrap_o = tick_i & ~clr_i & (cnt_q == ONE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned   CNT_W     = 24,
  parameter bit            CAL_NOREF = 1'b0,
  parameter bit            CAL_SKEW  = 1'b0,
  parameter int unsigned   CAL_TENMS = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              core_src_o,
  output logic              ie_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam logic [31:0] CALIB_WORD =
    (32'(CAL_NOREF) << CAL_NOREF_BIT) | (32'(CAL_SKEW) << CAL_SKEW_BIT) |
    32'(CAL_TENMS[CNT_W-1:0]);

  reg_sel_e   rsel;
  logic       acc, wr_ctrl, wr_reload, rd_ctrl;
  logic [2:0] ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic       flag_q, irq_q;
  logic       unused_wdata;

  assign acc       = bus_sel_i & (bus_addr_i[1:0] == 2'b00);
  assign rsel      = reg_sel_e'(bus_addr_i[3:2]);
  assign wr_ctrl   = acc & bus_we_i & (rsel == REG_CTRL);
  assign wr_reload = acc & bus_we_i & (rsel == REG_RELOAD);
  assign clr_o     = acc & bus_we_i & (rsel == REG_CURR);
  assign rd_ctrl   = acc & ~bus_we_i & (rsel == REG_CTRL);
  assign unused_wdata = ^bus_wdata_i[31:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= bus_wdata_i[2:0];
      if (wr_reload) reload_q <= bus_wdata_i[CNT_W-1:0];
      // set beats clear so a wrap is never lost
      if (wrap_i)                 flag_q <= 1'b1;
      else if (rd_ctrl || clr_o)  flag_q <= 1'b0;
      irq_q <= wrap_i & ctrl_q[CTRL_IE_BIT];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (acc && !bus_we_i) begin
      unique case (rsel)
        REG_CTRL: begin
          bus_rdata_o[2:0]           = ctrl_q;
          bus_rdata_o[CTRL_WRAP_BIT] = flag_q;
        end
        REG_RELOAD: bus_rdata_o[CNT_W-1:0] = reload_q;
        REG_CURR:   bus_rdata_o[CNT_W-1:0] = cnt_i;
        REG_CALIB:  bus_rdata_o            = CALIB_WORD;
        default:    bus_rdata_o            = '0;
      endcase
    end
  end

  assign en_o       = ctrl_q[CTRL_EN_BIT];
  assign ie_o       = ctrl_q[CTRL_IE_BIT];
  assign core_src_o = ctrl_q[CTRL_SRC_BIT];
  assign reload_o   = reload_q;
  assign flag_o     = flag_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          CAL_NOREF   = 1'b0,
  parameter bit          CAL_SKEW    = 1'b0,
  parameter int unsigned CAL_TENMS   = 10000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_clk_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  logic             tick_en, cnt_clr, cnt_wrap;
  logic             cnt_en, core_src, irq_en, wrap_flag;
  logic [CNT_W-1:0] cnt_q, reload_q;

  tick_src_sel #(
    .SYNC_STAGES(SYNC_STAGES),
    .HAS_REF    (!CAL_NOREF)
  ) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .en_i      (cnt_en),
    .core_src_i(core_src),
    .tick_o    (tick_en)
  );

  tick_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_en),
    .clr_i   (cnt_clr),
    .reload_i(reload_q),
    .cnt_o   (cnt_q),
    .wrap_o  (cnt_wrap)
  );

  tick_regs #(
    .CNT_W    (CNT_W),
    .CAL_NOREF(CAL_NOREF),
    .CAL_SKEW (CAL_SKEW),
    .CAL_TENMS(CAL_TENMS)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_sel_i  (bus_sel_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .cnt_i      (cnt_q),
    .wrap_i     (cnt_wrap),
    .en_o       (cnt_en),
    .core_src_o (core_src),
    .ie_o       (irq_en),
    .reload_o   (reload_q),
    .clr_o      (cnt_clr),
    .flag_o     (wrap_flag),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             flag_i,
  input logic             ie_i,
  input logic             irq_i
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_i));

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_i == '0) |=> (cnt_i == $past(reload_i)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == '0 && !flag_i));

  assert_irq_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flag_i && $past(ie_i)));

  assert_irq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  assert_flag_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> ($past(cnt_i) == CNT_W'(1) && cnt_i == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_en),
  .clr_i   (cnt_clr),
  .cnt_i   (cnt_q),
  .reload_i(reload_q),
  .flag_i  (wrap_flag),
  .ie_i    (irq_en),
  .irq_i   (irq_o)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam logic [3:0]  A_CTRL = 4'h0, A_RELOAD = 4'h4, A_CURR = 4'h8, A_CALIB = 4'hC;
  localparam logic [31:0] CAL_EXP = 32'h4000_04D2;

  logic        clk_i = 1'b0, rst_ni = 1'b0, ref_clk_i = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  int total = 0, bad = 0, irq_cnt = 0;
  bit done = 1'b0;

  tick_timer #(.CAL_NOREF(1'b0), .CAL_SKEW(1'b1), .CAL_TENMS(1234)) i_tick_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;
  always @(negedge clk_i) if (rst_ni && irq_o) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wb(input logic [3:0] a, input logic [31:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", 32'(irq_o), 32'h0);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 reload", A_RELOAD, 32'h0);
    rd_chk("R1 curr", A_CURR, 32'h0);
    rd_chk("R10 calib", A_CALIB, CAL_EXP);
  endtask

  task automatic t_core_count;
    wb(A_RELOAD, 32'd3);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h5);
    rd_chk("R3 seq0", A_CURR, 32'd0);
    rd_chk("R3 seq1", A_CURR, 32'd3);
    rd_chk("R3 seq2", A_CURR, 32'd2);
    rd_chk("R3 seq3", A_CURR, 32'd1);
    rd_chk("R3 seq4", A_CURR, 32'd0);
    rd_chk("R3 seq5", A_CURR, 32'd3);
    wb(A_CTRL, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] a, b;
    rd(A_CURR, a);
    repeat (6) @(negedge clk_i);
    rd(A_CURR, b);
    check("R5 hold", b, a);
  endtask

  task automatic t_wrap_irq;
    logic [31:0] d;
    rd(A_CTRL, d);
    wb(A_RELOAD, 32'd2);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h7);
    repeat (3) @(negedge clk_i);
    check("R8 irq on wrap", 32'(irq_o), 32'h1);
    rd_chk("R7 flag set", A_CTRL, 32'h0001_0007);
    check("R8 irq one cycle", 32'(irq_o), 32'h0);
    rd_chk("R7 flag read-clear", A_CTRL, 32'h0000_0007);
    wb(A_CTRL, 32'h0);
  endtask

  task automatic t_no_ie;
    logic [31:0] d;
    int n;
    rd(A_CTRL, d);
    n = irq_cnt;
    wb(A_RELOAD, 32'd1);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h5);
    repeat (10) @(negedge clk_i);
    wb(A_CTRL, 32'h0);
    check("R8 no irq when disabled", 32'(irq_cnt), 32'(n));
    rd_chk("R7 flag without irq", A_CTRL, 32'h0001_0000);
  endtask

  task automatic t_zero_reload;
    logic [31:0] d;
    int n;
    rd(A_CTRL, d);
    n = irq_cnt;
    wb(A_RELOAD, 32'd0);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h7);
    repeat (10) @(negedge clk_i);
    check("R4 no irq", 32'(irq_cnt), 32'(n));
    rd_chk("R4 stays 0", A_CURR, 32'h0);
    rd_chk("R4 no flag", A_CTRL, 32'h7);
    wb(A_CTRL, 32'h0);
  endtask

  task automatic t_cur_clear;
    wb(A_RELOAD, 32'd100);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h5);
    repeat (5) @(negedge clk_i);
    wb(A_CURR, 32'hDEAD_BEEF);
    rd_chk("R6 clear beats tick", A_CURR, 32'd0);
    rd_chk("R6 reload after clear", A_CURR, 32'd100);
    wb(A_RELOAD, 32'd1);
    wb(A_CURR, 32'h0);
    repeat (4) @(negedge clk_i);
    wb(A_CURR, 32'h7);
    rd_chk("R6 flag cleared", A_CTRL, 32'h5);
    wb(A_CTRL, 32'h0);
  endtask

  task automatic t_ref;
    logic [31:0] d;
    rd(A_CTRL, d);
    wb(A_RELOAD, 32'd5);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'h1);
    repeat (10) @(negedge clk_i);
    rd_chk("R9 no tick on steady ref", A_CURR, 32'd0);
    ref_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rd_chk("R9 not before third edge", A_CURR, 32'd0);
    rd_chk("R9 tick at third edge", A_CURR, 32'd5);
    repeat (8) @(negedge clk_i);
    ref_clk_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rd_chk("R9 falling edge ignored", A_CURR, 32'd5);
    ref_clk_i = 1'b1;
    repeat (6) @(negedge clk_i);
    rd_chk("R9 second rise", A_CURR, 32'd4);
    wb(A_CTRL, 32'h0);
    ref_clk_i = 1'b0;
  endtask

  task automatic t_wide;
    wb(A_RELOAD, 32'hFFFF_FFFF);
    rd_chk("R11 reload width", A_RELOAD, 32'h00FF_FFFF);
    wb(A_CURR, 32'h0);
    wb(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl unused bits", A_CTRL, 32'h7);
    rd_chk("R11 full load", A_CURR, 32'h00FF_FFFF);
    rd_chk("R11 full step", A_CURR, 32'h00FF_FFFE);
    wb(A_CTRL, 32'h0);
    rd_chk("R2 misaligned reads 0", 4'h5, 32'h0);
    wb(4'h6, 32'h0000_0123);
    rd_chk("R2 misaligned write ignored", A_RELOAD, 32'h00FF_FFFF);
  endtask

  task automatic t_calib;
    wb(A_CALIB, 32'h0);
    rd_chk("R10 calib write ignored", A_CALIB, CAL_EXP);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_core_count;
    t_hold;
    t_wrap_irq;
    t_no_ie;
    t_zero_reload;
    t_cur_clear;
    t_ref;
    t_wide;
    t_calib;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule